// File: doc/BRIEF.md
# Complementary Dead-Time Generator with Brake

This block turns a single PWM waveform into a complementary pair of drive signals, one positive and one negative, for a half-bridge style power stage. When insertion is enabled, each output waits through its own programmable number of clock cycles before it switches on. The positive output counts from the PWM's rising edge and the negative output counts from the falling edge. As a result, the two outputs are never active at the same moment while the stage runs normally. With insertion disabled, the positive output copies the PWM input and the negative output is its inverse.

An external brake pin overrides the waveform. The pin first passes through a two-flop synchronizer. When it matches the programmed trigger level and braking is enabled, a brake latch sets and both outputs move to their programmed idle levels. The latch holds until software pulses the clear input, even after the pin has returned to its inactive level. The configuration inputs (enable, the two dead-time values, brake enable, brake polarity, idle levels) are expected to come from a register bank outside this block.

Top module: `dtg_pair`

## Requirements
- R1: While reset is asserted, both outputs are 0 and the brake latch is clear.
- R2: Both outputs are registered. With insertion disabled and no brake, out_p equals pwm_in as sampled at the previous clock edge and out_n equals its inverse.
- R3: With insertion enabled, out_p is 1 after an edge only if pwm_in has been sampled 1 on at least dt_pos+1 consecutive edges, ending with that edge. out_p falls at the first edge that samples pwm_in as 0.
- R4: With insertion enabled, out_n is 1 after an edge only if pwm_in has been sampled 0 on at least dt_neg+1 consecutive edges, ending with that edge. out_n falls at the first edge that samples pwm_in as 1.
- R5: A PWM high pulse lasting dt_pos samples or fewer produces no pulse on out_p. The same holds for low pulses and dt_neg on out_n.
- R6: While the brake latch is clear, out_p and out_n are never both 1.
- R7: The brake triggers when brk_en is 1 and the synchronized pin equals brk_pol (1 = trigger on high, 0 = trigger on low). If the pin is first sampled active at edge k, the outputs take their idle levels after edge k+2 and not before.
- R8: Once the brake is set it holds, regardless of the pin, until a cycle in which brk_clr is 1 and no new trigger is present. An active trigger wins over brk_clr in the same cycle.
- R9: While braked, out_p equals idle_p and out_n equals idle_n, each chosen independently (0 = low, 1 = high). This applies whether insertion is enabled or not.
- R10: With brk_en at 0, the brake pin has no effect on the outputs.
- R11: Dead-time values cover the full 10-bit range up to 1023. The internal run counters saturate, so a PWM level held for longer than the dead time keeps its output on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | PWM waveform to be split |
| dt_en | input | 1 | 1 = insert dead time, 0 = plain complementary copy |
| dt_pos | input | 10 | Turn-on delay of out_p, in clock cycles |
| dt_neg | input | 10 | Turn-on delay of out_n, in clock cycles |
| brk_pin | input | 1 | Asynchronous brake pin |
| brk_en | input | 1 | Brake function enable |
| brk_pol | input | 1 | Pin level that triggers the brake |
| brk_clr | input | 1 | Clears the brake latch |
| idle_p | input | 1 | Level of out_p while braked |
| idle_n | input | 1 | Level of out_n while braked |
| out_p | output | 1 | Positive drive output |
| out_n | output | 1 | Negative drive output |

## Verification
Two events can land on the same edge: a new brake trigger and a software clear. The bench holds the pin active, pulses brk_clr, and confirms that the outputs stay at their idle levels. It also confirms that the same clear with the pin inactive releases them on the following edge. The second collision is a brake onset that coincides with a PWM transition or with a dead-time count expiring. Random stimulus places brake pulses at arbitrary points in the waveform, and a cycle model in the bench judges every output value from R3, R4, R7 and R9.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    // One bit per leg of the complementary pair
    typedef struct packed {
        logic p;
        logic n;
    } pair_t;

endpackage

// File: rtl/dtg_run_delay.sv
// Counts consecutive samples of one input level and reports when the
// programmed turn-on delay has been covered.
module dtg_run_delay #(
    parameter int DT_W    = 10,
    parameter bit ACT_LVL = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sig_in,
    input  logic            dly_en,
    input  logic [DT_W-1:0] dly,
    output logic            want
);

    localparam int CNT_W = DT_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] run;
    } run_st_t;

    run_st_t st_d, st_q;
    logic    at_level;

    always_comb begin
        st_d     = st_q;
        at_level = (sig_in == ACT_LVL);
        if (!at_level) begin
            st_d.run = '0;
        end else if (st_q.run != CNT_MAX) begin
            st_d.run = st_q.run + 1'b1;
        end
        // run length includes the current sample
        if (dly_en) begin
            want = at_level && (st_d.run > {1'b0, dly});
        end else begin
            want = at_level;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/dtg_brake_latch.sv
// Synchronizes the brake pin, compares it with the trigger level and
// holds the brake until software clears it.
module dtg_brake_latch #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic pol,
    input  logic en,
    input  logic clr,
    output logic brake_now,
    output logic brake_hold
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   hold;
    } brk_st_t;

    brk_st_t st_d, st_q;
    logic    trig;

    always_comb begin
        st_d         = st_q;
        st_d.sync[0] = pin;
        for (int i = 1; i < SYNC_STAGES; i++) begin
            st_d.sync[i] = st_q.sync[i-1];
        end
        trig      = en && (st_q.sync[SYNC_STAGES-1] == pol);
        // a live trigger outranks the clear
        st_d.hold = (st_q.hold && !clr) || trig;
        brake_now = st_d.hold;
    end

    assign brake_hold = st_q.hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/dtg_pair.sv
module dtg_pair #(
    parameter int DT_W        = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwm_in,
    input  logic            dt_en,
    input  logic [DT_W-1:0] dt_pos,
    input  logic [DT_W-1:0] dt_neg,
    input  logic            brk_pin,
    input  logic            brk_en,
    input  logic            brk_pol,
    input  logic            brk_clr,
    input  logic            idle_p,
    input  logic            idle_n,
    output logic            out_p,
    output logic            out_n
);

    import dtg_pkg::*;

    logic  want_p, want_n;
    logic  brake_now, brake_hold;
    pair_t o_d, o_q;

    dtg_run_delay #(.DT_W(DT_W), .ACT_LVL(1'b1)) u_pos (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (pwm_in),
        .dly_en (dt_en),
        .dly    (dt_pos),
        .want   (want_p)
    );

    dtg_run_delay #(.DT_W(DT_W), .ACT_LVL(1'b0)) u_neg (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (pwm_in),
        .dly_en (dt_en),
        .dly    (dt_neg),
        .want   (want_n)
    );

    dtg_brake_latch #(.SYNC_STAGES(SYNC_STAGES)) u_brk (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin        (brk_pin),
        .pol        (brk_pol),
        .en         (brk_en),
        .clr        (brk_clr),
        .brake_now  (brake_now),
        .brake_hold (brake_hold)
    );

    always_comb begin
        o_d = o_q;
        if (brake_now) begin
            o_d.p = idle_p;
            o_d.n = idle_n;
        end else begin
            o_d.p = want_p;
            o_d.n = want_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign out_p = o_q.p;
    assign out_n = o_q.n;

endmodule

// File: rtl/dtg_pair_chk.sv
module dtg_pair_chk (
    input logic clk,
    input logic rst_n,
    input logic pwm_in,
    input logic dt_en,
    input logic brk_clr,
    input logic idle_p,
    input logic idle_n,
    input logic out_p,
    input logic out_n,
    input logic brake_now,
    input logic brake_hold
);

    // R6
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !brake_hold |-> !(out_p && out_n));

    // R2
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dt_en && !brake_now) |=> (out_p == $past(pwm_in) && out_n == !$past(pwm_in)));

    // R9
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brake_now |=> (out_p == $past(idle_p) && out_n == $past(idle_n)));

    // R8
    brake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (brake_hold && !brk_clr) |=> brake_hold);

    // R3
    pos_needs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dt_en && !brake_now) |=> (!out_p || $past(pwm_in)));

    // R4
    neg_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dt_en && !brake_now) |=> (!out_n || !$past(pwm_in)));

endmodule

bind dtg_pair dtg_pair_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwm_in     (pwm_in),
    .dt_en      (dt_en),
    .brk_clr    (brk_clr),
    .idle_p     (idle_p),
    .idle_n     (idle_n),
    .out_p      (out_p),
    .out_n      (out_n),
    .brake_now  (brake_now),
    .brake_hold (brake_hold)
);

// File: tb/dtg_pair_test.sv
`timescale 1ns/1ps
module dtg_pair_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwm_in = 1'b0;
    logic       dt_en = 1'b0;
    logic [9:0] dt_pos = '0;
    logic [9:0] dt_neg = '0;
    logic       brk_pin = 1'b0;
    logic       brk_en = 1'b0;
    logic       brk_pol = 1'b1;
    logic       brk_clr = 1'b0;
    logic       idle_p = 1'b0;
    logic       idle_n = 1'b0;
    logic       out_p, out_n;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dtg_pair uut (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .dt_en(dt_en),
        .dt_pos(dt_pos), .dt_neg(dt_neg), .brk_pin(brk_pin), .brk_en(brk_en),
        .brk_pol(brk_pol), .brk_clr(brk_clr), .idle_p(idle_p), .idle_n(idle_n),
        .out_p(out_p), .out_n(out_n)
    );

    // cycle model built from the requirements
    int m_rp, m_rn;
    bit m_s1, m_s2, m_lat, e_p, e_n, m_act;

    function automatic int sat_next(int r, bit lvl);
        if (!lvl) return 0;
        return (r >= 2047) ? 2047 : r + 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rp = 0; m_rn = 0; m_s1 = 0; m_s2 = 0; m_lat = 0; e_p = 0; e_n = 0;
        end else begin
            m_act = brk_en && (m_s2 == brk_pol);
            m_s2  = m_s1;
            m_s1  = brk_pin;
            m_lat = (m_lat && !brk_clr) || m_act;
            m_rp  = sat_next(m_rp, pwm_in);
            m_rn  = sat_next(m_rn, !pwm_in);
            if (m_lat) begin
                e_p = idle_p; e_n = idle_n;
            end else if (dt_en) begin
                e_p = pwm_in && (m_rp > int'(dt_pos));
                e_n = !pwm_in && (m_rn > int'(dt_neg));
            end else begin
                e_p = pwm_in; e_n = !pwm_in;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock, then compare against the model away from the edge
    task automatic tick();
        string tag;
        @(posedge clk);
        @(negedge clk);
        if (m_lat) tag = "R9";
        else if (!dt_en) tag = "R2";
        else if (pwm_in) tag = "R3";
        else tag = "R4";
        check({out_p, out_n} == {e_p, e_n}, tag, {out_p, out_n}, {e_p, e_n});
        if (!m_lat) check(!(out_p && out_n), "R6", {out_p, out_n}, 0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #1600000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int seen;
        void'($urandom(32'd2024));
        // R1 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_p == 0 && out_n == 0, "R1", {out_p, out_n}, 0);
        rst_n = 1'b1;

        // R2 plain complementary copy
        for (int i = 0; i < 40; i++) begin
            pwm_in = 1'($urandom);
            tick();
        end

        // R3 R4 exact delays
        dt_en = 1; dt_pos = 10'd5; dt_neg = 10'd3;
        pwm_in = 0; ticks(8);
        pwm_in = 1;
        seen = 0;
        for (int i = 0; i < 10; i++) begin
            tick();
            if (out_p && seen == 0) seen = i + 1;
        end
        check(seen == 6, "R3", seen, 6);
        pwm_in = 0;
        seen = 0;
        for (int i = 0; i < 8; i++) begin
            tick();
            if (out_n && seen == 0) seen = i + 1;
        end
        check(seen == 4, "R4", seen, 4);

        // R5 short pulses vanish
        seen = 0;
        pwm_in = 1;
        for (int i = 0; i < 5; i++) begin tick(); seen += out_p; end
        pwm_in = 0;
        for (int i = 0; i < 6; i++) begin tick(); seen += out_p; end
        check(seen == 0, "R5", seen, 0);
        pwm_in = 1; ticks(10);
        seen = 0;
        pwm_in = 0;
        for (int i = 0; i < 3; i++) begin tick(); seen += out_n; end
        pwm_in = 1; tick(); seen += out_n;
        check(seen == 0, "R5", seen, 0);

        // R11 full-range delay and saturation
        dt_pos = 10'd1023;
        pwm_in = 0; ticks(4);
        pwm_in = 1;
        ticks(1023);
        check(out_p == 0, "R11", out_p, 0);
        tick();
        check(out_p == 1, "R11", out_p, 1);
        ticks(1100);
        check(out_p == 1, "R11", out_p, 1);
        dt_pos = 10'd2;

        // R7 brake onset, trigger on high
        brk_en = 1; brk_pol = 1; idle_p = 1; idle_n = 0;
        pwm_in = 0; ticks(6);
        brk_pin = 1;
        ticks(2);
        check(out_p == 0 && out_n == 1, "R7", {out_p, out_n}, 1);
        tick();
        check(out_p == 1 && out_n == 0, "R7", {out_p, out_n}, 2);

        // R8 holds after pin release; clear loses to live trigger
        brk_clr = 1; tick(); brk_clr = 0;
        ticks(2);
        check(out_p == 1 && out_n == 0, "R8", {out_p, out_n}, 2);
        brk_pin = 0; ticks(10);
        check(out_p == 1 && out_n == 0, "R8", {out_p, out_n}, 2);
        brk_clr = 1; tick(); brk_clr = 0;
        ticks(2);
        check(out_p == 0 && out_n == 1, "R8", {out_p, out_n}, 1);

        // R7 trigger on low, R9 both idle high with insertion off
        brk_pin = 1; brk_pol = 0; ticks(4);
        dt_en = 0; idle_p = 1; idle_n = 1;
        brk_pin = 0; ticks(3);
        check(out_p == 1 && out_n == 1, "R9", {out_p, out_n}, 3);
        brk_pin = 1; ticks(3);
        brk_clr = 1; tick(); brk_clr = 0; ticks(2);

        // R10 brake disabled
        brk_en = 0; brk_pol = 1; brk_pin = 1; dt_en = 1;
        seen = 0;
        for (int i = 0; i < 60; i++) begin
            pwm_in = (i % 7) < 3;
            tick();
            seen += (out_p && out_n);
        end
        check(seen == 0 && !(out_p == idle_p && out_n == idle_n && pwm_in), "R10",
              {out_p, out_n}, 0);
        brk_pin = 0;

        // mixed random phase
        for (int blk = 0; blk < 40; blk++) begin
            dt_en  = ($urandom % 5) != 0;
            dt_pos = 10'($urandom % 12);
            dt_neg = 10'($urandom % 12);
            idle_p = 1'($urandom); idle_n = 1'($urandom);
            brk_en = 1'($urandom); brk_pol = 1'($urandom);
            for (int i = 0; i < 80; i++) begin
                if (($urandom % 6) == 0) pwm_in = ~pwm_in;
                brk_pin = (($urandom % 40) == 0) ? ~brk_pol : brk_pin;
                if (($urandom % 50) == 0) brk_pin = brk_pol;
                brk_clr = (($urandom % 25) == 0);
                tick();
            end
            brk_clr = 0;
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule